// File: doc/BRIEF.md
# Bank-Interleaved Read Scheduler

This block accepts a stream of read requests and spreads them over a set of independent memory banks. Each bank takes a fixed number of cycles per access. The low bits of each word address select the bank, and the upper bits form the address inside that bank. A request may start on a bank that is idle while other banks are still working. As a result, several accesses are in flight at once. Total throughput rises, but the time each single access takes does not change.

Requests are taken strictly in arrival order. If the bank that the oldest request needs is still busy, the request port stalls. A later request is never let past it, even when its own bank is free. Each bank returns its read data after its fixed latency. A small per-bank holding register catches that data. A FIFO of bank tags, written at issue, then releases the results on the response port in the order the requests were accepted.

The bank count must be a power of two, at least 2, and can be as large as 16 or more. The bank latency must be at least 2 cycles. When the latency is no larger than the bank count, an address stream that strides across the banks is accepted at one request per cycle.

Top module: `bank_interleave_sched`

## Requirements
- R1: The bank index of a request is `req_addr[log2(NUM_BANKS)-1:0]`, and the in-bank address is the remaining upper bits. One cycle after a request is accepted (`req_valid && req_ready` at a rising edge), exactly that bank's bit of `bank_cmd_valid` is high, and its slice of `bank_cmd_addr` (bits `b*BANK_AW +: BANK_AW`) holds the in-bank address. All other command valid bits are low.
- R2: A bank that has been issued a command cannot take another one for BANK_LAT cycles. Back-to-back requests to the same bank are therefore accepted exactly BANK_LAT cycles apart.
- R3: When consecutive requests go to banks that are not busy, one request is accepted every cycle. An address stream that steps through all banks in turn sustains this rate when BANK_LAT <= NUM_BANKS.
- R4: `req_ready` is low while the bank addressed by the request at the port is busy. The request then waits, and no later request is accepted ahead of it.
- R5: Responses appear on `rsp_valid`/`rsp_data` in the same order as the requests were accepted. Exactly one response is produced per accepted request.
- R6: Each response carries the word that its bank returned on `bank_rd_data`. `rsp_valid` rises BANK_LAT+2 rising edges after the edge at which its request was accepted.
- R7: After reset, `req_ready` is high, and every bit of `bank_cmd_valid` and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge when valid is also high |
| req_addr | input | ADDR_W | Word address of the read |
| bank_cmd_valid | output | NUM_BANKS | Per-bank read command strobe |
| bank_cmd_addr | output | NUM_BANKS*BANK_AW | Per-bank in-bank address, one slice per bank |
| bank_rd_valid | input | NUM_BANKS | Per-bank read data strobe, BANK_LAT cycles after the command |
| bank_rd_data | input | NUM_BANKS*DATA_W | Per-bank read data, one slice per bank |
| rsp_valid | output | 1 | Response word present for one cycle |
| rsp_data | output | DATA_W | Response word |

## Verification
The hardest case to reach is a request stalled behind a busy bank while the request that follows it targets an idle bank. This is exactly where a faulty design would either bypass the older request or lose the stall. A second hard case is a bank being re-issued in the same cycle that its previous result is still arriving.

The stimulus reaches the first case by sending two same-bank addresses followed at once by a different-bank address. It then checks both the stall length and the acceptance cycle of the third request. A continuous same-bank run reaches the second case, because there each re-issue lands exactly on the return of the earlier data. Strided, descending and high-address streams cover the full-rate path and the address split.

// File: rtl/bis_pkg.sv
package bis_pkg;

  // Width of an index able to select one of n items (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction

endpackage

// File: rtl/bis_bank_timer.sv
// Per-bank occupancy timer: busy for LAT cycles starting at the issue cycle.
module bis_bank_timer #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic free
);
  import bis_pkg::*;

  localparam int unsigned CW = cnt_w(LAT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (issue) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign free = (cnt_q == '0);

  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) // R2
    issue |-> free);

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) // R2
    issue |=> !free);

endmodule

// File: rtl/bis_rd_hold.sv
// Per-bank read-data holding register, released when its tag reaches the head.
module bis_rd_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              take,
  output logic              held,
  output logic [DATA_W-1:0] held_data
);

  logic held_q;
  logic held_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    held_d = held_q;
    if (take)     held_d = 1'b0;
    if (rd_valid) held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_valid) begin
      data_q <= rd_data;
    end
  end

  assign held      = held_q;
  assign held_data = data_q;

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n) // R6
    rd_valid |-> (!held_q || take));

  AST_TAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n) // R5
    take |-> held_q);

endmodule

// File: rtl/bis_tag_fifo.sv
// Issue-order FIFO of bank tags.
module bis_tag_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] din,
  input  logic             pop,
  output logic [TAG_W-1:0] dout,
  output logic             empty,
  output logic             full
);
  import bis_pkg::*;

  localparam int unsigned PW = idx_w(DEPTH);
  localparam int unsigned CW = cnt_w(DEPTH);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= din;
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) // R5
    push |-> (!full || pop));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) // R5
    pop |-> !empty);

endmodule

// File: rtl/bank_interleave_sched.sv
module bank_interleave_sched #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BANK_LAT  = 4,
  localparam int unsigned BANK_W   = bis_pkg::idx_w(NUM_BANKS),
  localparam int unsigned BANK_AW  = ADDR_W - BANK_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic [NUM_BANKS-1:0]           bank_cmd_valid,
  output logic [NUM_BANKS*BANK_AW-1:0]   bank_cmd_addr,
  input  logic [NUM_BANKS-1:0]           bank_rd_valid,
  input  logic [NUM_BANKS*DATA_W-1:0]    bank_rd_data,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_data
);

  // Live tags span acceptance to pop: BANK_LAT+2 at most, plus margin.
  localparam int unsigned TAG_DEPTH = NUM_BANKS + BANK_LAT;

  logic [BANK_W-1:0]    req_bank;
  logic [BANK_AW-1:0]   req_inaddr;
  logic [NUM_BANKS-1:0] bank_free;
  logic [NUM_BANKS-1:0] issue_vec;
  logic [NUM_BANKS-1:0] take_vec;
  logic [NUM_BANKS-1:0] held_vec;
  logic [DATA_W-1:0]    held_data [NUM_BANKS];
  logic                 accept;
  logic                 fifo_full;
  logic                 fifo_empty;
  logic [BANK_W-1:0]    head_tag;
  logic                 pop;

  logic [NUM_BANKS-1:0] cmd_valid_q;
  logic [BANK_AW-1:0]   cmd_addr_q [NUM_BANKS];
  logic                 rsp_valid_q;
  logic [DATA_W-1:0]    rsp_data_q;
  logic [DATA_W-1:0]    rsp_data_d;

  // Address split and admission.
  assign req_bank   = req_addr[BANK_W-1:0];
  assign req_inaddr = req_addr[ADDR_W-1:BANK_W];
  assign req_ready  = bank_free[req_bank] && !fifo_full;
  assign accept     = req_valid && req_ready;

  always_comb begin
    issue_vec = '0;
    if (accept) issue_vec[req_bank] = 1'b1;
  end

  // Per-bank timers, command registers and read-data holding.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bis_bank_timer #(.LAT(BANK_LAT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (issue_vec[b]),
      .free  (bank_free[b])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_valid_q[b] <= 1'b0;
      end else begin
        cmd_valid_q[b] <= issue_vec[b];
      end
    end

    always_ff @(posedge clk) begin
      if (issue_vec[b]) begin
        cmd_addr_q[b] <= req_inaddr;
      end
    end

    assign bank_cmd_addr[b*BANK_AW +: BANK_AW] = cmd_addr_q[b];
    assign take_vec[b] = pop && (head_tag == BANK_W'(b));

    bis_rd_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_valid  (bank_rd_valid[b]),
      .rd_data   (bank_rd_data[b*DATA_W +: DATA_W]),
      .take      (take_vec[b]),
      .held      (held_vec[b]),
      .held_data (held_data[b])
    );
  end

  assign bank_cmd_valid = cmd_valid_q;

  // Issue-order reassembly.
  bis_tag_fifo #(.DEPTH(TAG_DEPTH), .TAG_W(BANK_W)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (req_bank),
    .pop   (pop),
    .dout  (head_tag),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign pop = !fifo_empty && held_vec[head_tag];

  always_comb begin
    rsp_data_d = rsp_data_q;
    if (pop) rsp_data_d = held_data[head_tag];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) // R1
    $onehot0(bank_cmd_valid));

  AST_CMD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) // R1
    accept |=> ($countones(bank_cmd_valid) == 1));

  AST_RSP_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n) // R5
    pop |=> rsp_valid);

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) // R7
    ($past(!rst_n) && !fifo_full) |-> req_ready);

endmodule

// File: tb/sim_bank_interleave_sched.sv
`timescale 1ns/1ps
module sim_bank_interleave_sched;

  localparam int unsigned NB   = 4;
  localparam int unsigned AW   = 16;
  localparam int unsigned DW   = 32;
  localparam int unsigned LAT  = 4;
  localparam int unsigned BW   = 2;
  localparam int unsigned BAW  = AW - BW;

  logic clk;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [AW-1:0] req_addr;
  logic [NB-1:0] bank_cmd_valid;
  logic [NB*BAW-1:0] bank_cmd_addr;
  logic [NB-1:0] bank_rd_valid;
  logic [NB*DW-1:0] bank_rd_data;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  int n_chk;
  int n_fail;
  int cyc;
  logic [DW-1:0] exp_q[$];
  int            acc_q[$];

  bank_interleave_sched #(
    .NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .BANK_LAT(LAT)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .bank_cmd_valid(bank_cmd_valid), .bank_cmd_addr(bank_cmd_addr),
    .bank_rd_valid(bank_rd_valid), .bank_rd_data(bank_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // Fixed-latency bank models: a delay line of LAT stages per bank.
  logic [LAT-1:0] sh_v [NB];
  logic [BAW-1:0] sh_a [NB][LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        sh_v[b] <= '0;
      end else begin
        sh_v[b] <= {sh_v[b][LAT-2:0], bank_cmd_valid[b]};
        sh_a[b][0] <= bank_cmd_addr[b*BAW +: BAW];
        for (int s = 1; s < LAT; s++) sh_a[b][s] <= sh_a[b][s-1];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bank_rd_valid[b] = sh_v[b][LAT-1];
      bank_rd_data[b*DW +: DW] = word_of({sh_a[b][LAT-1], BW'(b)});
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as responses appear.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected response", rsp_data, 0);
      end else begin
        logic [DW-1:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        check(rsp_data == e, "R5/R6 response data", rsp_data, e);
        check(cyc == a + LAT + 2, "R6 response latency", cyc, a + LAT + 2);
      end
    end
  end

  // Driver: called at a falling edge; returns acceptance edge number and stall count.
  task automatic send(input logic [AW-1:0] a, output int acc, output int stalls);
    int b;
    b = int'(a % NB);
    stalls = 0;
    req_valid = 1'b1;
    req_addr  = a;
    #0.5;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #0.5;
    acc = cyc;
    exp_q.push_back(word_of(a));
    acc_q.push_back(acc);
    @(negedge clk);
    check(bank_cmd_valid == NB'(1 << b), "R1 command strobe", bank_cmd_valid, 1 << b);
    check(bank_cmd_addr[b*BAW +: BAW] == BAW'(a >> BW), "R1 in-bank address",
          bank_cmd_addr[b*BAW +: BAW], a >> BW);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 8) @(negedge clk);
    check(exp_q.size() == 0, "R5 all responses returned", exp_q.size(), 0);
  endtask

  bit done;

  initial begin
    int acc, prev, st;
    n_chk = 0; n_fail = 0; cyc = 0; done = 0;
    req_valid = 1'b0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
    check(bank_cmd_valid == '0, "R7 no commands after reset", bank_cmd_valid, 0);
    check(rsp_valid == 1'b0, "R7 no response after reset", rsp_valid, 0);

    // R3: striding stream, one accept per cycle
    for (int i = 0; i < 16; i++) begin
      send(AW'(i), acc, st);
      if (i > 0) check(acc == prev + 1, "R3 full-rate stride", acc - prev, 1);
      prev = acc;
    end
    drain();

    // R3: descending bank order at high addresses
    for (int i = 0; i < 8; i++) begin
      send(AW'(16'hFFFF - i), acc, st);
      if (i > 0) check(acc == prev + 1, "R3 descending stride", acc - prev, 1);
      prev = acc;
    end
    drain();

    // R2: same-bank run serialises at BANK_LAT spacing
    for (int i = 0; i < 4; i++) begin
      send(AW'(16'h0100 + 4 * i), acc, st);
      if (i > 0) check(acc == prev + LAT, "R2 same-bank spacing", acc - prev, LAT);
      prev = acc;
    end
    drain();

    // R4: stalled request is not bypassed by a later free-bank request
    send(16'h0202, acc, st);
    prev = acc;
    send(16'h0206, acc, st);
    check(st == LAT - 1, "R4 stall cycles with ready low", st, LAT - 1);
    check(acc == prev + LAT, "R4 busy-bank wait", acc - prev, LAT);
    prev = acc;
    send(16'h0203, acc, st);
    check(acc == prev + 1, "R4 follower accepted after stalled one", acc - prev, 1);
    drain();

    // R2/R3 mix: two banks alternating
    for (int i = 0; i < 6; i++) begin
      send(AW'(16'h0300 + (i % 2) + 4 * (i / 2)), acc, st);
      prev = acc;
    end
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule